// File: doc/BRIEF.md
# Stereo volume-to-attenuation update engine

This block keeps the playback level state for a bank of output channels: one level word per channel and one master word for each stereo side. Channel `c` belongs to side `c % 2`, so even channels follow the left master and odd channels follow the right master. Each word has a level field and a mute flag. When a request changes a word, the block works out a 7-bit attenuation code for every channel that depends on that word. It then passes codec register writes to a downstream serial writer.

The block first scales the channel level by its side's master level. It then converts the result to attenuation steps through a logarithmic table that is computed at elaboration. Every affected channel gets two writes to its own attenuation register. The first write latches the code. The second write repeats the code with the update flags set. A master change walks through every channel of that side. While that sequence runs, new requests are held off by the ready signal.

Top module: `vol_att_engine`

## Requirements
- R1: After reset, all channel words and both master words are muted with level 0. `req_ready_o` is 1 and `wr_valid_o` is 0.
- R2: If the channel's mute flag or its side master's mute flag is set, the channel's code is 0.
- R3: Otherwise the code is `127 - L[((cv*mv)/127) mod 256]`. Here `cv` is the channel level (0..127), `mv` is the side master level (0..255), `L[0]=127`, and `L[x]` is `20*log10(255/x)` rounded to the nearest integer.
- R4: Each channel evaluation gives two writes to address `c`, where `c` is the channel number. The first write carries `{2'b00, code}` and the second carries `code | 0x180`, in that order.
- R5: A change to master side `s` evaluates channels `s`, `s+2`, `s+4`, `s+6` in ascending order. A channel request evaluates only that channel.
- R6: A request whose value equals the stored field produces no writes.
- R7: A channel level request with a value above 127 is ignored. It produces no writes and leaves the stored level unchanged.
- R8: `req_ready_o` is 0 from the cycle after a changing request is accepted until its last write is accepted. A request presented while `req_ready_o` is 0 has no effect.
- R9: While `wr_valid_o` is 1 and `wr_ready_i` is 0, `wr_valid_o`, `wr_addr_o` and `wr_data_o` hold their values.
- R10: Request encoding uses `req_kind_i`:
  - 0 sets the channel level (`req_idx_i` is the channel, `req_data_i` is the level).
  - 1 sets the channel mute (`req_data_i[0]`, where 1 means muted).
  - 2 sets the master level (side is `req_idx_i[0]`, level is `req_data_i`).
  - 3 sets the master mute (side is `req_idx_i[0]`, mute is `req_data_i[0]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Update request valid |
| req_ready_o | output | 1 | Engine idle, request accepted |
| req_kind_i | input | 2 | Request kind (see R10) |
| req_idx_i | input | 3 | Channel number, or side in bit 0 |
| req_data_i | input | 8 | Level, or mute flag in bit 0 |
| wr_valid_o | output | 1 | Register write valid |
| wr_ready_i | input | 1 | Serial writer ready |
| wr_addr_o | output | 7 | Codec register address |
| wr_data_o | output | 9 | Codec register value |

## Verification
Directed cases start from the all-muted reset state. Removing the two mute layers one at a time separates a mute-forced zero from a zero-product table entry. The level pairs 127/255 and 100/255 pin the ends and the middle of the table. Repeated values and an out-of-range channel level show that no writes are issued, and a follow-up request with the old value confirms the stored level did not move. A request pulsed during a fan-out, then replayed later, shows it was dropped. Random request mixes are run under random writer stalls, and each write stream is compared by order against a model of the mute, scale and rounding rules.

// File: rtl/vae_pkg.sv
package vae_pkg;
  localparam int CH_LVL_W  = 7;
  localparam int MS_LVL_W  = 8;
  localparam int CODE_W    = 7;
  localparam int LUT_DEPTH = 1 << MS_LVL_W;
  localparam int CODE_MAX  = (1 << CODE_W) - 1;

  typedef enum logic [1:0] {
    K_CH_LVL  = 2'd0,
    K_CH_MUTE = 2'd1,
    K_MS_LVL  = 2'd2,
    K_MS_MUTE = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCALE, ST_LOOK, ST_WR_LATCH, ST_WR_UPD
  } eng_state_e;

  // round(20*log10(255/x)): count rounding thresholds 255*10^(-(k-0.5)/20) >= x.
  // Thresholds held in 2^-28 fixed point, stepped by 10^(-1/20).
  function automatic logic [CODE_W-1:0] log_att(input int unsigned x);
    logic [63:0] t;
    logic [CODE_W-1:0] n;
    if (x == 0) return CODE_W'(CODE_MAX);
    t = 64'd64621950016;
    n = '0;
    for (int k = 0; k < CODE_MAX; k++) begin
      if ((64'(x) << 28) <= t) n = n + 1'b1;
      t = (t * 64'd239243352) >> 28;
    end
    return n;
  endfunction
endpackage

// File: rtl/vae_scale.sv
module vae_scale
  import vae_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CH_LVL_W-1:0] ch_lvl_i,
  input  logic                ch_mute_i,
  input  logic [MS_LVL_W-1:0] ms_lvl_i,
  input  logic                ms_mute_i,
  output logic [MS_LVL_W-1:0] idx_o,
  output logic                mute_o
);
  localparam int PROD_W = CH_LVL_W + MS_LVL_W;
  localparam int DIV    = (1 << CH_LVL_W) - 1;

  logic [PROD_W-1:0] prod, quot;

  always_comb begin
    prod = PROD_W'(ch_lvl_i) * PROD_W'(ms_lvl_i);
    quot = prod / PROD_W'(DIV);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o  <= '0;
      mute_o <= 1'b1;
    end else begin
      idx_o  <= quot[MS_LVL_W-1:0];
      mute_o <= ch_mute_i | ms_mute_i;
    end
  end
endmodule

// File: rtl/vae_log_rom.sv
module vae_log_rom
  import vae_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [MS_LVL_W-1:0] idx_i,
  input  logic                mute_i,
  output logic [CODE_W-1:0]   code_o
);
  logic [CODE_W-1:0] rom [LUT_DEPTH];

  for (genvar x = 0; x < LUT_DEPTH; x++) begin : g_ent
    localparam logic [CODE_W-1:0] VAL = log_att(x);
    assign rom[x] = VAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_o <= '0;
    else if (mute_i) code_o <= '0;
    else code_o <= CODE_W'(CODE_MAX) - rom[idx_i];
  end
endmodule

// File: rtl/vol_att_engine.sv
module vol_att_engine
  import vae_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [MS_LVL_W-1:0] req_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int CH_MAX = (1 << CH_LVL_W) - 1;
  localparam logic [DATA_W-1:0] UPD_FLAGS = DATA_W'(9'h180);

  eng_state_e state;
  logic [CH_LVL_W-1:0] ch_lvl  [NUM_CH];
  logic                ch_mute [NUM_CH];
  logic [MS_LVL_W-1:0] ms_lvl  [2];
  logic                ms_mute [2];
  logic [IDX_W-1:0]    cur_ch;
  logic                fan;
  logic                chg, last;
  logic                side;
  logic [MS_LVL_W-1:0] sc_idx;
  logic                sc_mute;
  logic [CODE_W-1:0]   code;

  assign side = req_idx_i[0];
  assign last = (int'(cur_ch) + 2) >= NUM_CH;

  always_comb begin
    chg = 1'b0;
    case (req_kind_i)
      K_CH_LVL:  chg = (int'(req_data_i) <= CH_MAX) &&
                       (req_data_i[CH_LVL_W-1:0] != ch_lvl[req_idx_i]);
      K_CH_MUTE: chg = req_data_i[0] != ch_mute[req_idx_i];
      K_MS_LVL:  chg = req_data_i != ms_lvl[side];
      default:   chg = req_data_i[0] != ms_mute[side];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      cur_ch <= '0;
      fan    <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
        ch_lvl[i]  <= '0;
        ch_mute[i] <= 1'b1;
      end
      for (int i = 0; i < 2; i++) begin
        ms_lvl[i]  <= '0;
        ms_mute[i] <= 1'b1;
      end
    end else begin
      case (state)
        ST_IDLE: if (req_valid_i && chg) begin
          state <= ST_SCALE;
          case (req_kind_i)
            K_CH_LVL:  ch_lvl[req_idx_i]  <= req_data_i[CH_LVL_W-1:0];
            K_CH_MUTE: ch_mute[req_idx_i] <= req_data_i[0];
            K_MS_LVL:  ms_lvl[side]       <= req_data_i;
            default:   ms_mute[side]      <= req_data_i[0];
          endcase
          fan    <= req_kind_i[1];
          cur_ch <= req_kind_i[1] ? IDX_W'(side) : req_idx_i;
        end
        ST_SCALE:    state <= ST_LOOK;
        ST_LOOK:     state <= ST_WR_LATCH;
        ST_WR_LATCH: if (wr_ready_i) state <= ST_WR_UPD;
        ST_WR_UPD: if (wr_ready_i) begin
          if (fan && !last) begin
            cur_ch <= cur_ch + IDX_W'(2);
            state  <= ST_SCALE;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  vae_scale u_scale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ch_lvl_i  (ch_lvl[cur_ch]),
    .ch_mute_i (ch_mute[cur_ch]),
    .ms_lvl_i  (ms_lvl[cur_ch[0]]),
    .ms_mute_i (ms_mute[cur_ch[0]]),
    .idx_o     (sc_idx),
    .mute_o    (sc_mute)
  );

  vae_log_rom u_rom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (sc_idx),
    .mute_i (sc_mute),
    .code_o (code)
  );

  assign req_ready_o = state == ST_IDLE;
  assign wr_valid_o  = (state == ST_WR_LATCH) || (state == ST_WR_UPD);
  assign wr_addr_o   = ADDR_W'(cur_ch);
  assign wr_data_o   = (state == ST_WR_UPD) ? (DATA_W'(code) | UPD_FLAGS) : DATA_W'(code);
endmodule

// File: rtl/vol_att_engine_chk.sv
module vol_att_engine_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o
);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  assert_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !req_ready_o);

  assert_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_ready_i && wr_data_o[8:7] == 2'b00) |=>
      (wr_valid_o && wr_data_o == {2'b11, $past(wr_data_o[6:0])} && wr_addr_o == $past(wr_addr_o)));

  assert_form_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> ((wr_data_o[8:7] == 2'b00 || wr_data_o[8:7] == 2'b11) &&
                    int'(wr_addr_o) < NUM_CH));
endmodule

bind vol_att_engine vol_att_engine_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .wr_valid_o  (wr_valid_o),
  .wr_ready_i  (wr_ready_i),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o)
);

// File: tb/vol_att_engine_tb_top.sv
module vol_att_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = '0;
  logic [2:0] req_idx = '0;
  logic [7:0] req_data = '0;
  logic       wr_valid;
  logic       wr_ready = 1'b1;
  logic [6:0] wr_addr;
  logic [8:0] wr_data;

  int n_checks = 0;
  int n_fail = 0;
  bit stall_en = 1'b0;
  bit done = 1'b0;

  int m_cl [8];
  int m_cm [8];
  int m_ml [2];
  int m_mm [2];
  logic [15:0] exp_q[$];
  logic [15:0] got_q[$];

  always #10 clk = ~clk;

  vol_att_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_idx_i(req_idx), .req_data_i(req_data),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always @(negedge clk) begin
    bit r;
    r = stall_en ? (($urandom % 4) != 0) : 1'b1;
    wr_ready = r;
    if (rst_n && wr_valid && r) got_q.push_back({wr_addr[6:0], wr_data});
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lut(input int x);
    if (x == 0) return 127;
    return int'($floor(20.0 * $log10(255.0 / x) + 0.5));
  endfunction

  function automatic int code_of(input int c);
    int s;
    s = c % 2;
    if (m_cm[c] != 0 || m_mm[s] != 0) return 0;                 // R2
    return 127 - lut(((m_cl[c] * m_ml[s]) / 127) % 256);        // R3
  endfunction

  function automatic void push_ch(input int c);
    int k;
    k = code_of(c);
    exp_q.push_back({7'(c), 9'(k)});
    exp_q.push_back({7'(c), 9'(k | 'h180)});
  endfunction

  // model of R5..R7, R10
  function automatic void model(input int kind, input int idx, input int data);
    int s;
    s = idx % 2;
    case (kind)
      0: if (data <= 127 && data != m_cl[idx]) begin m_cl[idx] = data; push_ch(idx); end
      1: if ((data % 2) != m_cm[idx]) begin m_cm[idx] = data % 2; push_ch(idx); end
      2: if (data != m_ml[s]) begin
           m_ml[s] = data;
           for (int c = s; c < 8; c += 2) push_ch(c);
         end
      default: if ((data % 2) != m_mm[s]) begin
           m_mm[s] = data % 2;
           for (int c = s; c < 8; c += 2) push_ch(c);
         end
    endcase
  endfunction

  task automatic send(input int kind, input int idx, input int data);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_kind = 2'(kind); req_idx = 3'(idx); req_data = 8'(data);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    model(kind, idx, data);
  endtask

  task automatic settle_and_compare(input string req);
    int g;
    g = 0;
    while (!(req_ready && !wr_valid) && g < 1000) begin @(negedge clk); g++; end
    check(got_q.size() == exp_q.size(), {req, " write count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], {req, " write"}, int'(got_q[i]), int'(exp_q[i]));
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic run_req(input int kind, input int idx, input int data, input string req);
    send(kind, idx, data);
    settle_and_compare(req);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin m_cl[i] = 0; m_cm[i] = 1; end
    for (int i = 0; i < 2; i++) begin m_ml[i] = 0; m_mm[i] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(wr_valid == 1'b0, "R1 no write after reset", wr_valid, 0);

    run_req(0, 0, 100, "R1 R2 level while muted");
    run_req(3, 0, 0, "R5 left master unmute fan-out");
    run_req(1, 0, 0, "R2 R3 channel unmute zero product");
    run_req(2, 0, 255, "R3 R5 left master full");
    run_req(2, 0, 255, "R6 repeated master level");
    run_req(1, 0, 0, "R6 repeated channel mute");
    run_req(0, 0, 200, "R7 out-of-range level");
    run_req(0, 0, 100, "R7 stored level unchanged");
    run_req(0, 0, 127, "R3 top of table");
    run_req(3, 1, 0, "R5 right master fan-out");
    run_req(2, 1, 128, "R5 right master level");

    // R8: pulse a request while busy; it must be dropped
    send(2, 0, 77);
    req_kind = 2'd0; req_idx = 3'd2; req_data = 8'd55; req_valid = 1'b1;
    check(req_ready == 1'b0, "R8 busy during fan-out", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    settle_and_compare("R8 fan-out with dropped request");
    run_req(1, 2, 0, "R8 replay unmute channel 2");
    run_req(0, 2, 55, "R8 dropped level applied now");

    stall_en = 1'b1;
    run_req(2, 0, 200, "R9 fan-out under stalls");
    for (int n = 0; n < 150; n++) begin
      int kind, idx, data;
      kind = $urandom % 4;
      idx = $urandom % 8;
      data = (kind == 0) ? ($urandom % 140) : ((kind == 2) ? ($urandom % 256) : ($urandom % 2));
      run_req(kind, idx, data, "R3 R4 R10 random");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule